// File: doc/BRIEF.md
# Cell Histogram Row Aggregator

This block turns a raster stream of per-pixel gradients into oriented-gradient histograms of 8×8 pixel cells. Each accepted pixel carries a magnitude and an orientation code covering 0 to 180 degrees. The block splits the magnitude between the two nearest of nine orientation bins by linear interpolation. It sums the votes of each run of eight pixels that fall in one row of a cell into a partial histogram.

Partials go into a line buffer that holds one entry per cell column. With the default 640-pixel row, that is 80 entries. The entry is overwritten on the first pixel row of a cell row and added to on the next seven. After the eighth row the finished histogram is registered on the output. It comes with a one-cycle valid pulse and the cell's column and row.

The orientation code counts in steps of 1/STEP of a bin, where STEP = 2^SUB_W. Bin k has its centre at code k·STEP + STEP/2. Legal codes run from 0 to 9·STEP−1. Pixels arrive in raster order, gaps are allowed, and a frame is IMG_W × IMG_H pixels.

Top module: `cell_hist_agg`

## Requirements
- R1: While reset is asserted and after it is released, `cell_valid` is low and `cell_hist` is zero until the first cell completes. The raster position starts at the top-left pixel.
- R2: When the orientation code is exactly a bin centre (k·STEP + STEP/2), the whole magnitude goes to bin k and nothing goes to any other bin.
- R3: For any other code, let t = (code − STEP/2) mod (9·STEP), lo = floor(t/STEP) and f = t mod STEP. Bin (lo+1) mod 9 receives floor(mag·f/STEP) and bin lo receives the rest of mag.
- R4: Codes below STEP/2, and codes from 9·STEP − STEP/2 upward, share their magnitude between bin 8 and bin 0 (lo = 8, hi = 0).
- R5: `cell_valid` is a single-cycle pulse. It is high in the cycle after the clock edge that accepts the pixel at column offset 7 and row offset 7 of a cell, and at no other time.
- R6: With the pulse, `cell_col` and `cell_row` give the cell's column (x/8) and row (y/8). Bin b of the histogram is at `cell_hist[b*ACC_W +: ACC_W]`, where ACC_W = MAG_W+6.
- R7: A cycle with `pix_valid` low changes no position or sum and produces no pulse.
- R8: The first pixel row of each cell row replaces the buffered partial. No value from an earlier cell row or frame leaks into a new cell.
- R9: Each bin holds 64 full-scale magnitudes exactly, without wrap-around.
- R10: A frame produces (IMG_W/8)·(IMG_H/8) cells in raster order of cells. The line buffer has IMG_W/8 entries, which is 80 for a 640-pixel row.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock, rising edge |
| rst_n | input | 1 | Active-low synchronous reset |
| pix_valid | input | 1 | A pixel is presented this cycle |
| pix_mag | input | MAG_W | Gradient magnitude |
| pix_ang | input | ANG_W | Orientation code, 0 to 9·STEP−1 |
| cell_valid | output | 1 | Finished cell histogram pulse |
| cell_col | output | CXW | Cell column index |
| cell_row | output | CYW | Cell row index |
| cell_hist | output | 9·ACC_W | Nine bin sums, bin 0 in the low bits |

## Verification
A wrong row counter or a lost buffer overwrite shows up at the ports at the next completed cell. The pulse lands in the wrong cycle, or the bins carry stale sums from the previous cell row, and a frame that follows a full-scale frame makes such leakage obvious. A wrong interpolation split shifts weight between neighbouring bins of the very cell that contains the pixel, so it is visible within eight pixel rows. The total over all bins still matches the sum of the magnitudes, so bins must be compared one by one. A miscounted position during idle gaps moves every later pulse and coordinate.

// File: rtl/cell_hist_agg.sv
module cell_hist_agg #(
  parameter int IMG_W = 640,
  parameter int IMG_H = 480,
  parameter int CELL  = 8,
  parameter int NBINS = 9,
  parameter int MAG_W = 8,
  parameter int SUB_W = 4,
  localparam int CB    = $clog2(CELL),
  localparam int XW    = $clog2(IMG_W),
  localparam int YW    = $clog2(IMG_H),
  localparam int CXW   = XW - CB,
  localparam int CYW   = YW - CB,
  localparam int NCOLS = IMG_W / CELL,
  localparam int NROWS = IMG_H / CELL,
  localparam int ACC_W = MAG_W + 2*CB,
  localparam int STEP  = 1 << SUB_W,
  localparam int HALF  = STEP / 2,
  localparam int SPAN  = NBINS * STEP,
  localparam int ANG_W = $clog2(SPAN),
  localparam int LW    = ANG_W - SUB_W + 1
) (
  input  logic                   clk,
  input  logic                   rst_n,
  input  logic                   pix_valid,
  input  logic [MAG_W-1:0]       pix_mag,
  input  logic [ANG_W-1:0]       pix_ang,
  output logic                   cell_valid,
  output logic [CXW-1:0]         cell_col,
  output logic [CYW-1:0]         cell_row,
  output logic [NBINS*ACC_W-1:0] cell_hist
);

  logic [XW-1:0] x_q;
  logic [YW-1:0] y_q;
  logic [CB-1:0] px, py;
  logic [CXW-1:0] cx;
  logic x_last, y_last, grp_end, cell_end;

  assign px       = x_q[CB-1:0];
  assign py       = y_q[CB-1:0];
  assign cx       = x_q[XW-1:CB];
  assign x_last   = (x_q == XW'(IMG_W-1));
  assign y_last   = (y_q == YW'(IMG_H-1));
  assign grp_end  = pix_valid && (px == CB'(CELL-1));
  assign cell_end = grp_end && (py == CB'(CELL-1));

  logic [ANG_W:0] ang_t;
  logic [LW-1:0]  lo_bin, hi_bin;
  logic [SUB_W-1:0] frac;
  logic [MAG_W-1:0] w_hi, w_lo;

  assign ang_t  = (pix_ang >= ANG_W'(HALF)) ? {1'b0, pix_ang} - (ANG_W+1)'(HALF)
                                           : {1'b0, pix_ang} + (ANG_W+1)'(SPAN-HALF);
  assign lo_bin = ang_t[ANG_W:SUB_W];
  assign hi_bin = (lo_bin == LW'(NBINS-1)) ? '0 : lo_bin + LW'(1);
  assign frac   = ang_t[SUB_W-1:0];
  assign w_hi   = MAG_W'(({{SUB_W{1'b0}}, pix_mag} * {{MAG_W{1'b0}}, frac}) >> SUB_W);
  assign w_lo   = pix_mag - w_hi;

  logic [NBINS-1:0][ACC_W-1:0] part_q, part_nx, merged, rd_q;
  logic [NBINS-1:0][ACC_W-1:0] line_mem [NCOLS];

  assign rd_q = line_mem[cx];

  for (genvar b = 0; b < NBINS; b++) begin : g_bin
    logic [MAG_W-1:0] vote;
    assign vote       = (lo_bin == LW'(b)) ? w_lo :
                        (hi_bin == LW'(b)) ? w_hi : '0;
    assign part_nx[b] = ((px == '0) ? '0 : part_q[b]) + ACC_W'(vote);
    assign merged[b]  = ((py == '0) ? '0 : rd_q[b]) + part_nx[b];
  end

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      x_q        <= '0;
      y_q        <= '0;
      part_q     <= '0;
      cell_valid <= 1'b0;
      cell_col   <= '0;
      cell_row   <= '0;
      cell_hist  <= '0;
    end else begin
      cell_valid <= cell_end;
      if (pix_valid) begin
        part_q <= part_nx;
        if (x_last) begin
          x_q <= '0;
          y_q <= y_last ? '0 : y_q + YW'(1);
        end else begin
          x_q <= x_q + XW'(1);
        end
      end
      if (cell_end) begin
        cell_col  <= cx;
        cell_row  <= y_q[YW-1:CB];
        cell_hist <= merged;
      end
    end
  end

  always_ff @(posedge clk) begin
    if (grp_end) line_mem[cx] <= merged;
  end

endmodule

// File: rtl/cell_hist_agg_chk.sv
module cell_hist_agg_chk #(
  parameter int NBINS = 9,
  parameter int ACC_W = 14,
  parameter int MAG_W = 8,
  parameter int CELL  = 8,
  parameter int CXW   = 7,
  parameter int CYW   = 6,
  parameter int NCOLS = 80,
  parameter int NROWS = 60
) (
  input logic                   clk,
  input logic                   rst_n,
  input logic                   pix_valid,
  input logic                   cell_valid,
  input logic [CXW-1:0]         cell_col,
  input logic [CYW-1:0]         cell_row,
  input logic [NBINS*ACC_W-1:0] cell_hist
);
  localparam longint BOUND = longint'(CELL*CELL) * ((longint'(1) << MAG_W) - 1);

  longint total;
  always_comb begin
    total = 0;
    for (int b = 0; b < NBINS; b++) total += longint'(cell_hist[b*ACC_W +: ACC_W]);
  end

  AST_SINGLE_PULSE: assert property (@(posedge clk) disable iff (!rst_n)
    cell_valid |=> !cell_valid); // R5
  AST_IDLE_SILENT: assert property (@(posedge clk) disable iff (!rst_n)
    !pix_valid |=> !cell_valid); // R7
  AST_COORD_RANGE: assert property (@(posedge clk) disable iff (!rst_n)
    cell_valid |-> (int'(cell_col) < NCOLS) && (int'(cell_row) < NROWS)); // R6
  AST_NO_OVERFLOW: assert property (@(posedge clk) disable iff (!rst_n)
    cell_valid |-> total <= BOUND); // R9
endmodule

bind cell_hist_agg cell_hist_agg_chk #(
  .NBINS(NBINS), .ACC_W(ACC_W), .MAG_W(MAG_W), .CELL(CELL),
  .CXW(CXW), .CYW(CYW), .NCOLS(NCOLS), .NROWS(NROWS)
) i_chk (
  .clk(clk), .rst_n(rst_n), .pix_valid(pix_valid), .cell_valid(cell_valid),
  .cell_col(cell_col), .cell_row(cell_row), .cell_hist(cell_hist)
);

// File: tb/test_cell_hist_agg.sv
module test_cell_hist_agg;
  localparam int W = 64, H = 24, CELL = 8, NB = 9, MW = 8, SW = 4;
  localparam int NC = W / CELL, NR = H / CELL, AW = MW + 6;
  localparam int STEP = 1 << SW, SPAN = NB * STEP;

  logic clk = 1'b0;
  always #5 clk = ~clk;

  logic rst_n, pix_valid;
  logic [MW-1:0] pix_mag;
  logic [7:0] pix_ang;
  logic cell_valid;
  logic [2:0] cell_col;
  logic [1:0] cell_row;
  logic [NB*AW-1:0] cell_hist;

  cell_hist_agg #(.IMG_W(W), .IMG_H(H), .CELL(CELL), .NBINS(NB), .MAG_W(MW), .SUB_W(SW))
    i_cell_hist_agg (.clk(clk), .rst_n(rst_n), .pix_valid(pix_valid), .pix_mag(pix_mag),
                     .pix_ang(pix_ang), .cell_valid(cell_valid), .cell_col(cell_col),
                     .cell_row(cell_row), .cell_hist(cell_hist));

  int checks = 0, fails = 0, emitted = 0;
  int ref_sum[NR][NC][NB];
  int ref_cnt[NR][NC];
  int bx = 0, by = 0;
  int exp_c, exp_r;
  int exp_h[NB];
  bit exp_v;
  string tag;

  task automatic chk(string req, string what, longint act, longint expv);
    checks++;
    if (act != expv) begin
      fails++;
      $display("FAIL %s %s actual=%0d expected=%0d", req, what, act, expv);
    end
  endtask

  task automatic cycle(bit v, int mag, int ang);
    pix_valid = v; pix_mag = MW'(mag); pix_ang = 8'(ang);
    exp_v = 0;
    if (v) begin
      int lo = 0, f = 0, r = by / CELL, c = bx / CELL, wh;
      for (int k = 0; k < NB; k++) begin
        int d = (ang - (k*STEP + STEP/2) + SPAN) % SPAN;
        if (d < STEP) begin lo = k; f = d; end
      end
      wh = (mag * f) / STEP;
      if (ref_cnt[r][c] == 0) for (int k = 0; k < NB; k++) ref_sum[r][c][k] = 0;
      ref_sum[r][c][lo] += mag - wh;
      ref_sum[r][c][(lo + 1) % NB] += wh;
      ref_cnt[r][c]++;
      if (ref_cnt[r][c] == CELL*CELL) begin
        exp_v = 1; exp_c = c; exp_r = r; ref_cnt[r][c] = 0;
        for (int k = 0; k < NB; k++) exp_h[k] = ref_sum[r][c][k];
      end
      bx++;
      if (bx == W) begin bx = 0; by = (by + 1) % H; end
    end
    @(negedge clk);
    chk(v ? "R5" : "R7", "cell_valid", cell_valid, exp_v);
    if (exp_v && cell_valid) begin
      emitted++;
      chk("R6", "cell_col", cell_col, exp_c);
      chk("R6", "cell_row", cell_row, exp_r);
      for (int k = 0; k < NB; k++) chk(tag, $sformatf("bin%0d", k), cell_hist[k*AW +: AW], exp_h[k]);
    end
  endtask

  task automatic run_frame(int mode, string t);
    tag = t; emitted = 0;
    for (int y = 0; y < H; y++) begin
      for (int x = 0; x < W; x++) begin
        int mag, ang;
        case (mode)
          0: begin ang = ((x + 2*y) % NB) * STEP + STEP/2; mag = (x*7 + y*3 + 1) % 256; end
          1: begin ang = (x*13 + y*29) % SPAN; mag = (x*11 + y*5) % 256; end
          2: begin
               ang = ((x + y) % 2 == 0) ? (x*3 + y) % (STEP/2) : SPAN - STEP/2 + (x + 5*y) % (STEP/2);
               mag = (x*17 + y) % 256;
             end
          default: begin ang = (x*7 + y) % SPAN; mag = 255; end
        endcase
        if ((x*3 + y) % 11 == 0) cycle(0, 0, 0);
        cycle(1, mag, ang);
      end
    end
    cycle(0, 0, 0);
    chk("R10", "cells per frame", emitted, NC*NR);
  endtask

  initial begin
    for (int r = 0; r < NR; r++) for (int c = 0; c < NC; c++) ref_cnt[r][c] = 0;
    rst_n = 0; pix_valid = 0; pix_mag = '0; pix_ang = '0; tag = "R1";
    repeat (3) @(negedge clk);
    chk("R1", "cell_valid in reset", cell_valid, 0);
    chk("R1", "cell_hist zero", (cell_hist == '0) ? 1 : 0, 1);
    rst_n = 1;
    cycle(0, 0, 0);
    chk("R1", "cell_hist zero after reset", (cell_hist == '0) ? 1 : 0, 1);
    run_frame(0, "R2");
    run_frame(1, "R3");
    run_frame(2, "R4");
    run_frame(3, "R9");
    run_frame(0, "R8");
    $display("TB_RESULT checks=%0d failures=%0d", checks, fails);
    $finish;
  end

  initial begin
    repeat (200000) @(posedge clk);
    fails++;
    $display("FAIL R5 watchdog actual=running expected=finished");
    $display("TB_RESULT checks=%0d failures=%0d", checks, fails);
    $finish;
  end
endmodule